// File: doc/BRIEF.md
# Autoranging Four-Digit Frequency Readout Driver

This block turns a latched four-digit BCD count into a multiplexed seven-segment reading that is always in kHz. Along with the count it receives a two-bit range code, which says which gate the count was measured on, plus under-range and over-range flags. From these it decides where the decimal point sits. A reading in the tens of kHz shows as `dd.dd`, one in the hundreds of kHz as `ddd.d`, and one in the thousands as `dddd` with no point.

The digits are lit one at a time, starting at the leftmost. Each digit stays lit for a fixed dwell of `DWELL_CYCLES` clocks, which is sized for about 1 ms. When the input is below range, every digit shows 0. When it is above range, every digit shows the letter H. All outputs are active low and registered, so they follow the inputs one clock later. Measuring the signal and generating the gate happen elsewhere.

Top module: `freq_seg_display`

## Requirements
- R1: While `rst_n` is low, every segment, decimal-point and digit-select output is high (dark).
- R2: From the first clock after reset, exactly one `sel_n` bit is low. Digit 3 (leftmost) comes first, then 2, 1, 0, then 3 again, and each digit stays selected for `DWELL_CYCLES` clocks.
- R3: The selected digit `i` shows BCD value `bcd_in[4i+3:4i]`. The encoding is `seg_n[6:0]` = segments a,b,c,d,e,f,g, active low: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R4: In a normal reading, a BCD value from 10 to 15 shows a blank digit (`seg_n` = 1111111).
- R5: With `range_code` = 00 (tens of kHz), the decimal point lights only while digit 2 is selected, giving `dd.dd`.
- R6: With `range_code` = 01 (hundreds of kHz), the decimal point lights only while digit 1 is selected, giving `ddd.d`.
- R7: With `range_code` = 10 (thousands of kHz), the decimal point never lights.
- R8: When `under_flag` is high, and neither `over_flag` is high nor the range code is 11, every digit shows 0 and the decimal point stays dark.
- R9: When `over_flag` is high, or `range_code` = 11, every digit shows H (segments b,c,e,f,g lit, `seg_n` = 1001000) and the decimal point stays dark. This holds whatever `under_flag` is.
- R10: The outputs are registered: what appears after a clock edge depends on the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bcd_in | input | 16 | Four BCD digits; digit i at bits 4i+3..4i, digit 3 leftmost |
| range_code | input | 2 | 00 tens, 01 hundreds, 10 thousands of kHz, 11 reserved (over-range) |
| under_flag | input | 1 | Reading below range |
| over_flag | input | 1 | Reading above range |
| seg_n | output | 7 | Segments a..g of the selected digit, active low |
| dp_n | output | 1 | Decimal point of the selected digit, active low |
| sel_n | output | 4 | Digit enables, active low, bit i enables digit i |

## Verification
The checks compare each clock's outputs with the inputs sampled one edge earlier. They assume that the count, range code and flags are synchronous to `clk` and change at most once per clock. They also assume that reset is applied once at the start, and that no further reset arrives while a pattern is being checked. The stimulus changes inputs only on falling clock edges and uses a short dwell. It mixes held patterns, which run for a full scan of all four digits, with random changes in the middle of a dwell. The random changes include BCD codes above 9 and every combination of the flags.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  localparam int NUM_DIGITS = 4;
  localparam int SEG_W      = 7;
  localparam int BCD_W      = 4;

  typedef enum logic [1:0] {
    SHOW_NORMAL = 2'd0,
    SHOW_UNDER  = 2'd1,
    SHOW_OVER   = 2'd2
  } show_mode_e;

  // segment order a..g, bit 6 = a, active high
  localparam logic [SEG_W-1:0] GLYPH_H     = 7'b0110111;
  localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'b0000000;

  function automatic logic [SEG_W-1:0] bcd_glyph(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'd0: g = 7'b1111110;
      4'd1: g = 7'b0110000;
      4'd2: g = 7'b1101101;
      4'd3: g = 7'b1111001;
      4'd4: g = 7'b0110011;
      4'd5: g = 7'b1011011;
      4'd6: g = 7'b1011111;
      4'd7: g = 7'b1110000;
      4'd8: g = 7'b1111111;
      4'd9: g = 7'b1111011;
      default: g = GLYPH_BLANK;
    endcase
    return g;
  endfunction

  // over-range (or reserved range) wins over under-range
  function automatic show_mode_e pick_mode(input logic [1:0] rng,
                                           input logic over,
                                           input logic under);
    if (over || rng == 2'b11) return SHOW_OVER;
    if (under)                return SHOW_UNDER;
    return SHOW_NORMAL;
  endfunction

  // one-hot position of the decimal point for a normal reading
  function automatic logic [NUM_DIGITS-1:0] point_mask(input logic [1:0] rng);
    logic [NUM_DIGITS-1:0] m;
    m = '0;
    case (rng)
      2'b00:   m[2] = 1'b1;
      2'b01:   m[1] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fsd_scan_timer.sv
module fsd_scan_timer #(
  parameter int NUM_DIGITS   = 4,
  parameter int DWELL_CYCLES = 200000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [$clog2(NUM_DIGITS)-1:0] scan_pos
);
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam int POS_W = $clog2(NUM_DIGITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] dwell_cnt;
  logic             dwell_done;

  assign dwell_done = (dwell_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_cnt <= '0;
    end else if (dwell_done) begin
      dwell_cnt <= '0;
    end else begin
      dwell_cnt <= dwell_cnt + 1'b1;
    end
  end

  // leftmost digit first, then step right, wrap to leftmost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_pos <= POS_FIRST;
    end else if (dwell_done) begin
      if (scan_pos == '0) scan_pos <= POS_FIRST;
      else                scan_pos <= scan_pos - 1'b1;
    end
  end

endmodule

// File: rtl/fsd_glyph_map.sv
module fsd_glyph_map
  import fsd_pkg::*;
(
  input  logic [NUM_DIGITS*BCD_W-1:0]          bcd_in,
  input  logic [1:0]                           range_code,
  input  logic                                 under_flag,
  input  logic                                 over_flag,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0]     glyphs,
  output logic [NUM_DIGITS-1:0]                dp_mask
);
  show_mode_e            mode;
  logic [NUM_DIGITS-1:0] pt_pos;

  assign mode   = pick_mode(range_code, over_flag, under_flag);
  assign pt_pos = point_mask(range_code);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    always_comb begin
      case (mode)
        SHOW_OVER: begin
          glyphs[g]  = GLYPH_H;
          dp_mask[g] = 1'b0;
        end
        SHOW_UNDER: begin
          glyphs[g]  = bcd_glyph(4'd0);
          dp_mask[g] = 1'b0;
        end
        default: begin
          glyphs[g]  = bcd_glyph(bcd_in[g*BCD_W +: BCD_W]);
          dp_mask[g] = pt_pos[g];
        end
      endcase
    end
  end

endmodule

// File: rtl/fsd_digit_drive.sv
module fsd_digit_drive
  import fsd_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(NUM_DIGITS)-1:0]     scan_pos,
  input  logic [NUM_DIGITS-1:0][SEG_W-1:0]  glyphs,
  input  logic [NUM_DIGITS-1:0]             dp_mask,
  output logic [SEG_W-1:0]                  seg_n,
  output logic                              dp_n,
  output logic [NUM_DIGITS-1:0]             sel_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n <= '1;
      dp_n  <= 1'b1;
      sel_n <= '1;
    end else begin
      seg_n <= ~glyphs[scan_pos];
      dp_n  <= ~dp_mask[scan_pos];
      sel_n <= ~(NUM_DIGITS'(1) << scan_pos);
    end
  end

endmodule

// File: rtl/freq_seg_display.sv
module freq_seg_display
  import fsd_pkg::*;
#(
  parameter int DWELL_CYCLES = 200000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_DIGITS*BCD_W-1:0]  bcd_in,
  input  logic [1:0]                   range_code,
  input  logic                         under_flag,
  input  logic                         over_flag,
  output logic [SEG_W-1:0]             seg_n,
  output logic                         dp_n,
  output logic [NUM_DIGITS-1:0]        sel_n
);
  localparam int POS_W = $clog2(NUM_DIGITS);

  logic [POS_W-1:0]                scan_pos;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] glyphs;
  logic [NUM_DIGITS-1:0]           dp_mask;

  fsd_scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_pos(scan_pos)
  );

  fsd_glyph_map u_map (
    .bcd_in    (bcd_in),
    .range_code(range_code),
    .under_flag(under_flag),
    .over_flag (over_flag),
    .glyphs    (glyphs),
    .dp_mask   (dp_mask)
  );

  fsd_digit_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_pos(scan_pos),
    .glyphs  (glyphs),
    .dp_mask (dp_mask),
    .seg_n   (seg_n),
    .dp_n    (dp_n),
    .sel_n   (sel_n)
  );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker
  import fsd_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            range_code,
  input logic                  under_flag,
  input logic                  over_flag,
  input logic [SEG_W-1:0]      seg_n,
  input logic                  dp_n,
  input logic [NUM_DIGITS-1:0] sel_n
);
  logic [NUM_DIGITS-1:0] sel_q;
  logic                  lit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_n;
  end

  assign lit = ~&sel_n;

  // R1: dark while reset is held
  a_r1_reset_dark: assert property (@(posedge clk)
    !rst_n |-> (&sel_n && &seg_n && dp_n));

  // R2: never more than one digit enabled
  a_r2_single_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);

  // R2: every change of selection moves one digit to the right, wrapping
  a_r2_scan_order: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != sel_q && sel_q != '1) |-> (sel_n == {sel_q[0], sel_q[NUM_DIGITS-1:1]}));

  // R5, R6, R7: a lit point only on the digit the range places it on
  a_r5_point_place: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_n |-> (!$past(over_flag) && !$past(under_flag) &&
               (($past(range_code) == 2'b00 && !sel_n[2]) ||
                ($past(range_code) == 2'b01 && !sel_n[1]))));

  // R8: under-range shows zeros
  a_r8_under_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (lit && $past(under_flag) && !$past(over_flag) && $past(range_code) != 2'b11)
      |-> (seg_n == ~bcd_glyph(4'd0) && dp_n));

  // R9: over-range shows H on every digit
  a_r9_over_h: assert property (@(posedge clk) disable iff (!rst_n)
    (lit && ($past(over_flag) || $past(range_code) == 2'b11))
      |-> (seg_n == ~GLYPH_H && dp_n));

endmodule

bind freq_seg_display fsd_checker u_fsd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .range_code(range_code),
  .under_flag(under_flag),
  .over_flag (over_flag),
  .seg_n     (seg_n),
  .dp_n      (dp_n),
  .sel_n     (sel_n)
);

// File: tb/freq_seg_display_test.sv
module freq_seg_display_test;

  localparam int DWELL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] bcd_in = '0;
  logic [1:0]  range_code = '0;
  logic        under_flag = 1'b0;
  logic        over_flag = 1'b0;
  logic [6:0]  seg_n;
  logic        dp_n;
  logic [3:0]  sel_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  freq_seg_display #(.DWELL_CYCLES(DWELL)) uut (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .range_code(range_code),
    .under_flag(under_flag), .over_flag(over_flag),
    .seg_n(seg_n), .dp_n(dp_n), .sel_n(sel_n)
  );

  // active-low glyph for a value, written from the R3/R4 tables
  function automatic logic [6:0] low_glyph(input int v);
    case (v)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      5: return 7'b0100100;
      6: return 7'b0100000;
      7: return 7'b0001111;
      8: return 7'b0000000;
      9: return 7'b0000100;
      default: return 7'b1111111;
    endcase
  endfunction

  // reference model state
  int         cyc_n = 0;
  bit         have_exp = 0;
  logic [6:0] e_seg;
  logic       e_dp;
  logic [3:0] e_sel;
  string      seg_tag, dp_tag, sel_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc_n = 0;
      e_seg = 7'h7F; e_dp = 1'b1; e_sel = 4'hF;
      seg_tag = "R1"; dp_tag = "R1"; sel_tag = "R1";
      have_exp = 1;
    end else if (have_exp) begin
      int p;
      int d;
      p = 3 - ((cyc_n / DWELL) % 4);
      d = int'(bcd_in[p*4 +: 4]);
      e_sel = 4'hF;
      e_sel[p] = 1'b0;
      sel_tag = "R2";
      if (over_flag || range_code == 2'b11) begin
        e_seg = 7'b1001000; e_dp = 1'b1;
        seg_tag = "R9"; dp_tag = "R9";
      end else if (under_flag) begin
        e_seg = low_glyph(0); e_dp = 1'b1;
        seg_tag = "R8"; dp_tag = "R8";
      end else begin
        e_seg = low_glyph(d);
        seg_tag = (d > 9) ? "R4" : "R3/R10";
        case (range_code)
          2'b00: begin e_dp = !(p == 2); dp_tag = "R5"; end
          2'b01: begin e_dp = !(p == 1); dp_tag = "R6"; end
          default: begin e_dp = 1'b1; dp_tag = "R7"; end
        endcase
      end
      cyc_n++;
    end
  end

  always @(negedge clk) begin
    if (have_exp && !done) begin
      n_cmp += 3;
      if (sel_n !== e_sel) begin
        n_bad++;
        $display("FAIL %s sel_n: actual %b expected %b at %0t", sel_tag, sel_n, e_sel, $time);
      end
      if (seg_n !== e_seg) begin
        n_bad++;
        $display("FAIL %s seg_n: actual %b expected %b at %0t", seg_tag, seg_n, e_seg, $time);
      end
      if (dp_n !== e_dp) begin
        n_bad++;
        $display("FAIL %s dp_n: actual %b expected %b at %0t", dp_tag, dp_n, e_dp, $time);
      end
    end
  end

  task automatic hold(input logic [15:0] b, input logic [1:0] r,
                      input logic u, input logic o, input int cycles);
    @(negedge clk);
    bcd_in = b; range_code = r; under_flag = u; over_flag = o;
    repeat (cycles - 1) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);   // R1 checked while held
    rst_n = 1'b1;
    hold(16'h1234, 2'b00, 0, 0, 4*DWELL + 3);  // R5 dd.dd
    hold(16'h3456, 2'b01, 0, 0, 4*DWELL);      // R6 ddd.d
    hold(16'h9870, 2'b10, 0, 0, 4*DWELL);      // R7 no point
    hold(16'h5555, 2'b00, 1, 0, 4*DWELL);      // R8 zeros
    hold(16'h5555, 2'b01, 0, 1, 4*DWELL);      // R9 H
    hold(16'h0000, 2'b00, 1, 1, 4*DWELL);      // R9 priority
    hold(16'h4321, 2'b11, 0, 0, 4*DWELL);      // R9 reserved range
    hold(16'hAFBC, 2'b10, 0, 0, 4*DWELL);      // R4 blanks
    hold(16'h6789, 2'b00, 0, 0, 4*DWELL);      // R3 remaining glyphs
    for (int k = 0; k < 150; k++) begin       // R10 mid-dwell changes
      hold(16'($urandom), 2'($urandom), 1'(($urandom % 5) == 0),
           1'(($urandom % 6) == 0), 1 + int'($urandom % 7));
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule